// File: doc/BRIEF.md
# VBUS Power Enable and Fault Controller

This block drives the enable of the external regulator that supplies VBUS on a dual-role USB port. Power is switched on only while the port runs as host and software asks for it. In device mode the enable is held low, so the port never pushes current onto a bus that another host already powers.

The regulator's fault line is active low and arrives asynchronously. It passes through a synchronizer and then a debounce filter. A fault that survives the filter sets a sticky status bit. Two configuration inputs choose the response, and they may be used together:
- One input cuts power at once.
- The other input raises a level interrupt to the processor.

After an automatic cutoff, power stays off until software clears the status and then makes a fresh power request.

Top module: `vbus_pwr_ctrl`

## Requirements
- R1: While reset is applied, and for the cycles the internal reset release takes, `pwr_en_o`, `fault_sts_o` and `fault_irq_o` are 0. Reset is asserted asynchronously. It is released after two clock edges, and the enable register needs one more edge.
- R2: In the cycle after any cycle in which `host_mode_i` is 0, `pwr_en_o` is 0.
- R3: When `host_mode_i` and `pwr_req_i` are both 1 and no cutoff lockout is pending, `pwr_en_o` is 1 one clock edge later. When `pwr_req_i` drops, `pwr_en_o` follows one edge later.
- R4: `pwr_fault_n_i` is active low and goes through a two-flop synchronizer. A low pulse shorter than `DEB_CYCLES` clock cycles has no effect on any output.
- R5: If `pwr_fault_n_i` goes low and stays low, `fault_sts_o` becomes 1 on clock edge `DEB_CYCLES+2` counted from the input change. It is still 0 after edge `DEB_CYCLES+1`. The return to the no-fault state is filtered in the same way.
- R6: With `cfg_auto_cut_i`=1, `pwr_en_o` falls on the same edge that sets `fault_sts_o`. With `cfg_auto_cut_i`=0, a fault leaves `pwr_en_o` unchanged.
- R7: After an automatic cutoff, `pwr_en_o` stays 0 until two things have happened: `fault_sts_o` has been cleared, and `pwr_req_i` has been seen at 0. When `pwr_req_i` then returns to 1, power comes back one edge later.
- R8: `fault_irq_o` is 1 exactly when `fault_sts_o` is 1 and `cfg_irq_en_i` is 1. The interrupt response and the cutoff response are independent of each other.
- R9: `fault_sts_o` is sticky. It is cleared by a one-cycle 1 on `fault_clr_i` (write-one-to-clear). If a qualified fault and a clear arrive in the same cycle, the fault wins.
- R10: Only a filtered change from no-fault to fault sets `fault_sts_o`. A fault held continuously after a clear does not set the status again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode_i | input | 1 | 1 when the port currently acts as host |
| pwr_req_i | input | 1 | Software request to power VBUS |
| pwr_fault_n_i | input | 1 | Asynchronous regulator fault, active low |
| cfg_auto_cut_i | input | 1 | A qualified fault removes power automatically |
| cfg_irq_en_i | input | 1 | A fault status drives the interrupt |
| fault_clr_i | input | 1 | Write-one-to-clear strobe for the fault status |
| pwr_en_o | output | 1 | External regulator enable |
| fault_sts_o | output | 1 | Sticky fault status |
| fault_irq_o | output | 1 | Fault interrupt, level |

## Verification
The assertions check several properties on every cycle:
- the host-mode gate and the cleared outputs during reset;
- that the enable is never high without a request one cycle earlier;
- that the status stays set until cleared, and that a cutoff or a qualified fault has its effect on the next edge;
- that the filtered fault changes only after a disagreement and that the debounce count stays bounded.

Other behaviour can only be shown by the bench's scenarios. These are the exact debounce boundary, the clock edge on which the status sets, the release of the lockout through a clear followed by a fresh request, the rule that a set beats a clear in the same cycle, and the absence of a repeat status while a fault is held.

// File: rtl/vbus_pwr_pkg.sv
package vbus_pwr_pkg;

  typedef struct packed {
    logic auto_cut;
    logic irq_en;
  } fault_cfg_t;

  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/vbus_rst_sync.sv
module vbus_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/vbus_fault_filter.sv
module vbus_fault_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_n_i,
  output logic fault_lvl_o,
  output logic fault_rise_o
);

  localparam int unsigned CW = vbus_pwr_pkg::cnt_bits(DEB_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(DEB_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   lvl;
  logic                   filt_q, filt_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   differ;
  logic                   at_limit;

  // synchronizer stages, first stage samples the inverted (active-high) fault
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      assign sync_d[g] = ~fault_n_i;
    end else begin : g_next
      assign sync_d[g] = sync_q[g-1];
    end
  end

  assign lvl      = sync_q[SYNC_STAGES-1];
  assign differ   = lvl ^ filt_q;
  assign at_limit = (cnt_q == LIMIT);

  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (differ) begin
      if (at_limit) filt_d = lvl;
      else          cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign fault_lvl_o  = filt_q;
  assign fault_rise_o = differ & at_limit & ~filt_q;

  // R4: filtered level moves only after the synchronized level disagreed
  a_r4_change_needs_diff: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> $past(lvl != filt_q));

  // R4: debounce counter never passes its limit
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

endmodule

// File: rtl/vbus_fault_status.sv
module vbus_fault_status (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rise_i,
  input  logic                     clr_i,
  input  logic                     req_i,
  input  vbus_pwr_pkg::fault_cfg_t cfg_i,
  output logic                     sts_o,
  output logic                     lock_o,
  output logic                     cut_now_o,
  output logic                     irq_o
);

  logic sts_q, sts_d;
  logic lock_q, lock_d;
  logic cut;

  assign cut = rise_i & cfg_i.auto_cut;

  always_comb begin
    sts_d = sts_q;
    if (rise_i)     sts_d = 1'b1;
    else if (clr_i) sts_d = 1'b0;
  end

  always_comb begin
    lock_d = lock_q;
    if (cut)                          lock_d = 1'b1;
    else if (lock_q && !sts_q && !req_i) lock_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      sts_q  <= sts_d;
      lock_q <= lock_d;
    end
  end

  assign sts_o     = sts_q;
  assign lock_o    = lock_q;
  assign cut_now_o = cut;
  assign irq_o     = sts_q & cfg_i.irq_en;

  // R9: status stays set until a clear strobe
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q && !clr_i |=> sts_q);

  // R9: a qualified fault sets status next edge, even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> sts_q);

  // R7: lockout cannot release while the status is still set
  a_r7_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && sts_q |=> lock_q);

endmodule

// File: rtl/vbus_pwr_ctrl.sv
module vbus_pwr_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_mode_i,
  input  logic pwr_req_i,
  input  logic pwr_fault_n_i,
  input  logic cfg_auto_cut_i,
  input  logic cfg_irq_en_i,
  input  logic fault_clr_i,
  output logic pwr_en_o,
  output logic fault_sts_o,
  output logic fault_irq_o
);

  import vbus_pwr_pkg::*;

  logic       rst_s_n;
  logic       flt_lvl;
  logic       flt_rise;
  logic       lock;
  logic       cut_now;
  logic       en_q, en_d;
  fault_cfg_t cfg;

  assign cfg.auto_cut = cfg_auto_cut_i;
  assign cfg.irq_en   = cfg_irq_en_i;

  vbus_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  vbus_fault_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .DEB_CYCLES  (DEB_CYCLES)
  ) u_filt (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .fault_n_i    (pwr_fault_n_i),
    .fault_lvl_o  (flt_lvl),
    .fault_rise_o (flt_rise)
  );

  vbus_fault_status u_sts (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .rise_i    (flt_rise),
    .clr_i     (fault_clr_i),
    .req_i     (pwr_req_i),
    .cfg_i     (cfg),
    .sts_o     (fault_sts_o),
    .lock_o    (lock),
    .cut_now_o (cut_now),
    .irq_o     (fault_irq_o)
  );

  always_comb begin
    en_d = host_mode_i & pwr_req_i & ~lock & ~cut_now;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) en_q <= 1'b0;
    else          en_q <= en_d;
  end

  assign pwr_en_o = en_q;

  // R1: enable is held off while the internal reset is active
  a_r1_off_in_reset: assert property (@(posedge clk)
    !rst_s_n |-> !pwr_en_o);

  // R2: not host in one cycle means no enable in the next
  a_r2_host_gate: assert property (@(posedge clk) disable iff (!rst_s_n)
    !host_mode_i |=> !pwr_en_o);

  // R3: enable only follows a request seen one cycle earlier
  a_r3_needs_req: assert property (@(posedge clk) disable iff (!rst_s_n)
    pwr_en_o |-> $past(pwr_req_i));

  // R6: automatic cutoff drops the enable on the next edge
  a_r6_cut: assert property (@(posedge clk) disable iff (!rst_s_n)
    cut_now |=> !pwr_en_o);

  // R5: status can only appear together with a filtered fault level
  a_r5_sts_needs_fault: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(fault_sts_o) |-> flt_lvl);

endmodule

// File: tb/vbus_pwr_ctrl_test.sv
module vbus_pwr_ctrl_test;

  localparam int unsigned DEB = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic host, req, fault_n, auto_cut, irq_en, clr;
  logic pwr_en, sts, irq;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  vbus_pwr_ctrl #(.SYNC_STAGES(2), .DEB_CYCLES(DEB)) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_mode_i    (host),
    .pwr_req_i      (req),
    .pwr_fault_n_i  (fault_n),
    .cfg_auto_cut_i (auto_cut),
    .cfg_irq_en_i   (irq_en),
    .fault_clr_i    (clr),
    .pwr_en_o       (pwr_en),
    .fault_sts_o    (sts),
    .fault_irq_o    (irq)
  );

  // reference model built from the requirements
  logic m_s1, m_s2, m_filt, m_en, m_sts, m_lock;
  int   m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_filt <= 0; m_cnt <= 0;
      m_en <= 0; m_sts <= 0; m_lock <= 0;
    end else begin : model_step
      logic rise;
      rise = 1'b0;
      if (m_s2 != m_filt) begin
        if (m_cnt == DEB - 1) begin
          m_filt <= m_s2; m_cnt <= 0; rise = m_s2;
        end else m_cnt <= m_cnt + 1;
      end else m_cnt <= 0;
      m_en   <= host & req & !m_lock & !(rise & auto_cut);
      m_sts  <= rise ? 1'b1 : (clr ? 1'b0 : m_sts);
      m_lock <= (rise & auto_cut) ? 1'b1 : (m_lock & (m_sts | req));
      m_s2 <= m_s1;
      m_s1 <= ~fault_n;
    end
  end

  function automatic logic exp_irq(input logic s, input logic e);
    return s & e;
  endfunction

  task automatic check(input string req_tag, input string what,
                       input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      if (n_fail < 20)
        $display("FAIL %s %s: actual=%b expected=%b at %0t", req_tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0; host = 1; req = 1; fault_n = 1; auto_cut = 0; irq_en = 0; clr = 0;
    step(3);
    check("R1", "en in reset", pwr_en, 0);
    check("R1", "sts in reset", sts, 0);
    check("R1", "irq in reset", irq, 0);
    rst_n = 1;
    step(1);
    check("R1", "en during release", pwr_en, 0);
    step(2);
    check("R3", "en on", pwr_en, 1);

    host = 0; step(1);
    check("R2", "en off in device", pwr_en, 0);
    host = 1; step(1);
    check("R2", "en back as host", pwr_en, 1);
    req = 0; step(1);
    check("R3", "en follows req low", pwr_en, 0);
    req = 1; step(1);
    check("R3", "en follows req high", pwr_en, 1);

    auto_cut = 1; irq_en = 1;
    fault_n = 0; step(DEB - 1); fault_n = 1; step(DEB + 4);
    check("R4", "short pulse sts", sts, 0);
    check("R4", "short pulse en", pwr_en, 1);

    fault_n = 0; step(DEB + 1);
    check("R5", "sts not yet", sts, 0);
    check("R5", "en before cut", pwr_en, 1);
    step(1);
    check("R5", "sts set", sts, 1);
    check("R6", "auto cut", pwr_en, 0);
    check("R8", "irq on", irq, 1);

    fault_n = 1; step(DEB + 4);
    clr = 1; step(1); clr = 0;
    check("R9", "cleared", sts, 0);
    check("R8", "irq cleared", irq, 0);
    check("R7", "still locked", pwr_en, 0);
    step(3);
    check("R7", "locked until re-request", pwr_en, 0);
    req = 0; step(1); req = 1; step(1);
    check("R7", "re-request powers", pwr_en, 1);

    auto_cut = 0; irq_en = 0;
    fault_n = 0; step(DEB + 2);
    check("R5", "sts set again", sts, 1);
    check("R6", "no cut when disabled", pwr_en, 1);
    check("R8", "irq masked", irq, 0);
    irq_en = 1; #1;
    check("R8", "irq unmasked", irq, 1);

    clr = 1; step(1); clr = 0;
    check("R9", "clear", sts, 0);
    step(10);
    check("R10", "held fault no reset", sts, 0);

    fault_n = 1; step(DEB + 4);
    fault_n = 0; step(DEB + 1);
    clr = 1; step(1); clr = 0;
    check("R9", "set wins over clear", sts, 1);

    // second reset, then random traffic against the model
    rst_n = 0; fault_n = 1; req = 0; clr = 0; step(2);
    rst_n = 1; step(5);
    begin : rnd
      int low_left, high_left;
      low_left = 0; high_left = 4;
      for (int c = 0; c < 3000; c++) begin
        if ($urandom_range(15) == 0) host = ~host;
        if ($urandom_range(7) == 0)  req = ~req;
        if ($urandom_range(63) == 0) auto_cut = ~auto_cut;
        if ($urandom_range(63) == 0) irq_en = ~irq_en;
        clr = ($urandom_range(19) == 0);
        if (low_left > 0) begin
          low_left--; fault_n = 0;
          if (low_left == 0) high_left = $urandom_range(2 * DEB, 1);
        end else if (high_left > 0) begin
          high_left--; fault_n = 1;
        end else if ($urandom_range(9) == 0) begin
          low_left = $urandom_range(2 * DEB + 3, 1); fault_n = 0;
        end
        step(1);
        check("R3", "random en", pwr_en, m_en);
        check("R9", "random sts", sts, m_sts);
        check("R8", "random irq", irq, exp_irq(m_sts, irq_en));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule